// File: doc/BRIEF.md
# Parser stage ternary CAM

This block is one step of a table-driven packet-header parser. Each lookup presents a parse state, three data bytes that an upstream fetcher has already sampled at configured offsets, and the current header pointer. The block compares that key with a small table of ternary entries. The enabled, matching entry with the lowest index selects a pair of action words. Those words give the next parse state, the layer to capture (layer id, layer type, flags), whether parsing ends, a bypass count, an error level and code, the data offsets for the next step, and the next header pointer.

The table, the actions, a disable bitmap and a stage enable bit are written through a simple register write port. Writes take effect on the clock edge, so a lookup in the same cycle still sees the old contents. Results are registered and appear one cycle after the lookup with a valid flag. Fetching packet bytes, chaining several steps and building the final search key are left to surrounding logic.

Top module: `hdr_stage_tcam`

## Requirements
- R1: A table write (cfg_kind 0) takes the compare value from cfg_wdata[31:0] and the care mask from cfg_wdata[63:32]. A key bit whose mask bit is 0 is a don't-care. A key bit whose mask bit is 1 must equal the value bit.
- R2: The 32-bit key is {in_dp2, in_dp1, in_dp0, in_state}, with in_state in bits 7:0.
- R3: When several enabled entries match, the lowest index wins and is reported on out_idx.
- R4: A disable write (cfg_kind 3) with cfg_idx 0 or 1 loads word 0 (entries 0..63) or word 1 (entries 64..127). Bit b of the word disables entry 64*word+b when set. Other cfg_idx values are ignored. After reset every entry is disabled.
- R5: The stage enable (cfg_kind 4, bit 0) is 0 after reset. While it is 0, no entry matches.
- R6: On a miss: out_hit=0, out_miss_err=1, out_done=1, out_idx and all other action outputs 0, and out_next_ptr=in_ptr. On a hit, out_miss_err=0.
- R7: On a hit, the first action word (cfg_kind 1) drives out_next_state[7:0], out_cap_ena[8], out_cap_lid[11:9], out_cap_ltype[15:12], out_cap_flags[23:16], out_done[24] and out_bypass[27:25].
- R8: On a hit, the second action word (cfg_kind 2) drives out_err_lev[3:0], out_err_code[11:4], out_dp0_off[19:12], out_dp1_off[27:20] and out_dp2_off[35:28].
- R9: out_next_ptr = in_ptr + advance[35:28], modulo 256. When the field select [37:36] is nonzero (1=dp0, 2=dp1, 3=dp2), the selected byte is ANDed with mask [45:38] and shifted by [49:47] bits. The shift is right when [46] is 1 and left otherwise (left shifts are truncated to 8 bits). The result is then added, modulo 256.
- R10: Table and action writes whose cfg_idx is NUM_ENTRIES or more are ignored.
- R11: out_valid is in_valid delayed by one clock. Result outputs update only for a valid lookup.
- R12: A write and a lookup in the same cycle: the lookup uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 3 | Write target: 0 table, 1 action word A, 2 action word B, 3 disable word, 4 stage enable |
| cfg_idx | input | IDX_W | Entry index, or disable word number |
| cfg_wdata | input | 64 | Write data |
| in_valid | input | 1 | Lookup request |
| in_state | input | 8 | Current parse state |
| in_dp0 | input | 8 | First sampled data byte |
| in_dp1 | input | 8 | Second sampled data byte |
| in_dp2 | input | 8 | Third sampled data byte |
| in_ptr | input | 8 | Current header pointer |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | An entry matched |
| out_miss_err | output | 1 | No entry matched |
| out_idx | output | ENT_W | Winning entry index |
| out_next_state | output | 8 | Next parse state |
| out_cap_ena | output | 1 | Capture this layer |
| out_cap_lid | output | 3 | Captured layer id |
| out_cap_ltype | output | 4 | Captured layer type |
| out_cap_flags | output | 8 | Captured layer flags |
| out_done | output | 1 | Parsing finished |
| out_bypass | output | 3 | Bypass count |
| out_err_lev | output | 4 | Error level |
| out_err_code | output | 8 | Error code |
| out_dp0_off | output | 8 | Next-stage offset for byte 0 |
| out_dp1_off | output | 8 | Next-stage offset for byte 1 |
| out_dp2_off | output | 8 | Next-stage offset for byte 2 |
| out_next_ptr | output | 8 | Next header pointer |

## Verification
A configuration write and a lookup can occur in the same cycle. The bench provokes this by asserting cfg_we and in_valid together: it rewrites the action of the entry that the lookup is known to select. The registered result must carry the old action. A second lookup right after must carry the new one. Priority and masking are judged by sweeping every parse state under four data patterns, over overlapping entries, with and without disabled entries.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  localparam int ST_W       = 8;
  localparam int DATA_W     = 8;
  localparam int PTR_W      = 8;
  localparam int KEY_W      = ST_W + 3 * DATA_W;
  localparam int CFG_W      = 64;
  localparam int MASK_LSB   = CFG_W / 2;
  localparam int DIS_WORD_W = 64;

  typedef enum logic [2:0] {
    CFG_CAM   = 3'd0,
    CFG_ACT0  = 3'd1,
    CFG_ACT1  = 3'd2,
    CFG_DIS   = 3'd3,
    CFG_STAGE = 3'd4
  } cfg_kind_e;

  // first action word, bit 0 at the bottom of the list
  typedef struct packed {
    logic [13:0]     rsvd;
    logic [2:0]      vl_shift;
    logic            vl_right;
    logic [7:0]      vl_mask;
    logic [1:0]      vl_sel;
    logic [7:0]      ptr_adv;
    logic [2:0]      bypass;
    logic            done;
    logic [7:0]      cap_flags;
    logic [3:0]      cap_ltype;
    logic [2:0]      cap_lid;
    logic            cap_ena;
    logic [ST_W-1:0] next_state;
  } act0_t;

  // second action word
  typedef struct packed {
    logic [27:0] rsvd;
    logic [7:0]  dp2_off;
    logic [7:0]  dp1_off;
    logic [7:0]  dp0_off;
    logic [7:0]  err_code;
    logic [3:0]  err_lev;
  } act1_t;

  function automatic logic [KEY_W-1:0] build_key(
    input logic [ST_W-1:0]   st,
    input logic [DATA_W-1:0] d0,
    input logic [DATA_W-1:0] d1,
    input logic [DATA_W-1:0] d2);
    return {d2, d1, d0, st};
  endfunction

  // a bit fails when it must be one but is zero, or must be zero but is one
  function automatic logic tern_hit(
    input logic [KEY_W-1:0] ones,
    input logic [KEY_W-1:0] zeros,
    input logic [KEY_W-1:0] key);
    return ~|((ones & ~key) | (zeros & key));
  endfunction

  function automatic logic [DATA_W-1:0] pick_field(
    input logic [1:0]        sel,
    input logic [DATA_W-1:0] d0,
    input logic [DATA_W-1:0] d1,
    input logic [DATA_W-1:0] d2);
    case (sel)
      2'd1:    return d0;
      2'd2:    return d1;
      2'd3:    return d2;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] vl_term(
    input logic [DATA_W-1:0] field,
    input logic [7:0]        mask,
    input logic              right,
    input logic [2:0]        shift);
    logic [DATA_W-1:0] masked;
    masked = field & mask;
    if (right) return PTR_W'(masked >> shift);
    return PTR_W'(masked << shift);
  endfunction

  function automatic logic [PTR_W-1:0] calc_next_ptr(
    input logic [PTR_W-1:0]  ptr,
    input act0_t             act,
    input logic [DATA_W-1:0] d0,
    input logic [DATA_W-1:0] d1,
    input logic [DATA_W-1:0] d2);
    logic [PTR_W-1:0] extra;
    extra = '0;
    if (act.vl_sel != 2'd0)
      extra = vl_term(pick_field(act.vl_sel, d0, d1, d2),
                      act.vl_mask, act.vl_right, act.vl_shift);
    return ptr + act.ptr_adv + extra;
  endfunction

endpackage

// File: rtl/hsp_entry_store.sv
module hsp_entry_store
  import hsp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_kind,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [KEY_W-1:0]       ones_q  [NUM_ENTRIES],
  output logic [KEY_W-1:0]       zeros_q [NUM_ENTRIES],
  output act0_t                  act0_q  [NUM_ENTRIES],
  output act1_t                  act1_q  [NUM_ENTRIES],
  output logic [NUM_ENTRIES-1:0] dis_q,
  output logic                   stage_en_q,
  output logic                   wr_entry_ok
);

  logic             idx_in_range;
  logic             is_entry_kind;
  logic             dis_wr;
  logic             stage_wr;
  logic [KEY_W-1:0] wr_val;
  logic [KEY_W-1:0] wr_msk;

  assign idx_in_range  = int'(cfg_idx) < NUM_ENTRIES;
  assign is_entry_kind = (cfg_kind == CFG_CAM) || (cfg_kind == CFG_ACT0) ||
                         (cfg_kind == CFG_ACT1);
  assign wr_entry_ok   = cfg_we && is_entry_kind && idx_in_range;
  assign dis_wr        = cfg_we && (cfg_kind == CFG_DIS);
  assign stage_wr      = cfg_we && (cfg_kind == CFG_STAGE);
  assign wr_val        = cfg_wdata[KEY_W-1:0];
  assign wr_msk        = cfg_wdata[MASK_LSB +: KEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        ones_q[e]  <= '0;
        zeros_q[e] <= '0;
        act0_q[e]  <= '0;
        act1_q[e]  <= '0;
      end
      dis_q      <= '1;
      stage_en_q <= 1'b0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (wr_entry_ok && int'(cfg_idx) == e) begin
          case (cfg_kind)
            CFG_CAM: begin
              ones_q[e]  <= wr_val & wr_msk;
              zeros_q[e] <= ~wr_val & wr_msk;
            end
            CFG_ACT0: act0_q[e] <= act0_t'(cfg_wdata);
            CFG_ACT1: act1_q[e] <= act1_t'(cfg_wdata);
            default: ;
          endcase
        end
        if (dis_wr && int'(cfg_idx) == e / DIS_WORD_W)
          dis_q[e] <= cfg_wdata[e % DIS_WORD_W];
      end
      if (stage_wr) stage_en_q <= cfg_wdata[0];
    end
  end

endmodule

// File: rtl/hsp_match.sv
module hsp_match
  import hsp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ENT_W       = 3
) (
  input  logic [KEY_W-1:0]       ones  [NUM_ENTRIES],
  input  logic [KEY_W-1:0]       zeros [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] dis,
  input  logic                   stage_en,
  input  logic [KEY_W-1:0]       key,
  output logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [NUM_ENTRIES-1:0] win_oh,
  output logic                   any_hit,
  output logic [ENT_W-1:0]       win_idx
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign hit_vec[g] = stage_en && !dis[g] && tern_hit(ones[g], zeros[g], key);
  end

  // scan from the top so that the last assignment is the lowest hit
  always_comb begin
    win_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) win_idx = ENT_W'(i);
  end

  assign win_oh  = hit_vec & (~hit_vec + NUM_ENTRIES'(1));
  assign any_hit = |hit_vec;

endmodule

// File: rtl/hsp_advance.sv
module hsp_advance
  import hsp_pkg::*;
(
  input  act0_t             act,
  input  logic [DATA_W-1:0] d0,
  input  logic [DATA_W-1:0] d1,
  input  logic [DATA_W-1:0] d2,
  input  logic [PTR_W-1:0]  ptr,
  output logic [PTR_W-1:0]  next_ptr
);

  assign next_ptr = calc_next_ptr(ptr, act, d0, d1, d2);

endmodule

// File: rtl/hdr_stage_tcam.sv
module hdr_stage_tcam
  import hsp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 7,
  localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [ST_W-1:0]   in_state,
  input  logic [DATA_W-1:0] in_dp0,
  input  logic [DATA_W-1:0] in_dp1,
  input  logic [DATA_W-1:0] in_dp2,
  input  logic [PTR_W-1:0]  in_ptr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_miss_err,
  output logic [ENT_W-1:0]  out_idx,
  output logic [ST_W-1:0]   out_next_state,
  output logic              out_cap_ena,
  output logic [2:0]        out_cap_lid,
  output logic [3:0]        out_cap_ltype,
  output logic [7:0]        out_cap_flags,
  output logic              out_done,
  output logic [2:0]        out_bypass,
  output logic [3:0]        out_err_lev,
  output logic [7:0]        out_err_code,
  output logic [7:0]        out_dp0_off,
  output logic [7:0]        out_dp1_off,
  output logic [7:0]        out_dp2_off,
  output logic [PTR_W-1:0]  out_next_ptr
);

  logic [KEY_W-1:0]       ones_w  [NUM_ENTRIES];
  logic [KEY_W-1:0]       zeros_w [NUM_ENTRIES];
  act0_t                  act0_w  [NUM_ENTRIES];
  act1_t                  act1_w  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] dis_w;
  logic                   stage_en_w;
  logic                   wr_entry_ok_w;
  logic [KEY_W-1:0]       key_w;
  logic [NUM_ENTRIES-1:0] hit_vec_w;
  logic [NUM_ENTRIES-1:0] win_oh_w;
  logic                   any_hit_w;
  logic [ENT_W-1:0]       win_idx_w;
  act0_t                  sel_a0;
  act1_t                  sel_a1;
  logic [PTR_W-1:0]       hit_ptr_w;
  logic                   rsvd_sink;

  assign key_w = build_key(in_state, in_dp0, in_dp1, in_dp2);

  hsp_entry_store #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_kind    (cfg_kind),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .ones_q      (ones_w),
    .zeros_q     (zeros_w),
    .act0_q      (act0_w),
    .act1_q      (act1_w),
    .dis_q       (dis_w),
    .stage_en_q  (stage_en_w),
    .wr_entry_ok (wr_entry_ok_w)
  );

  hsp_match #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ENT_W       (ENT_W)
  ) u_match (
    .ones     (ones_w),
    .zeros    (zeros_w),
    .dis      (dis_w),
    .stage_en (stage_en_w),
    .key      (key_w),
    .hit_vec  (hit_vec_w),
    .win_oh   (win_oh_w),
    .any_hit  (any_hit_w),
    .win_idx  (win_idx_w)
  );

  assign sel_a0 = act0_w[win_idx_w];
  assign sel_a1 = act1_w[win_idx_w];

  hsp_advance u_adv (
    .act      (sel_a0),
    .d0       (in_dp0),
    .d1       (in_dp1),
    .d2       (in_dp2),
    .ptr      (in_ptr),
    .next_ptr (hit_ptr_w)
  );

  // reserved action bits carry nothing
  assign rsvd_sink = ^{sel_a0.rsvd, sel_a1.rsvd, win_oh_w, wr_entry_ok_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_hit        <= 1'b0;
      out_miss_err   <= 1'b0;
      out_idx        <= '0;
      out_next_state <= '0;
      out_cap_ena    <= 1'b0;
      out_cap_lid    <= '0;
      out_cap_ltype  <= '0;
      out_cap_flags  <= '0;
      out_done       <= 1'b0;
      out_bypass     <= '0;
      out_err_lev    <= '0;
      out_err_code   <= '0;
      out_dp0_off    <= '0;
      out_dp1_off    <= '0;
      out_dp2_off    <= '0;
      out_next_ptr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (any_hit_w) begin
          out_hit        <= 1'b1;
          out_miss_err   <= 1'b0;
          out_idx        <= win_idx_w;
          out_next_state <= sel_a0.next_state;
          out_cap_ena    <= sel_a0.cap_ena;
          out_cap_lid    <= sel_a0.cap_lid;
          out_cap_ltype  <= sel_a0.cap_ltype;
          out_cap_flags  <= sel_a0.cap_flags;
          out_done       <= sel_a0.done;
          out_bypass     <= sel_a0.bypass;
          out_err_lev    <= sel_a1.err_lev;
          out_err_code   <= sel_a1.err_code;
          out_dp0_off    <= sel_a1.dp0_off;
          out_dp1_off    <= sel_a1.dp1_off;
          out_dp2_off    <= sel_a1.dp2_off;
          out_next_ptr   <= hit_ptr_w;
        end else begin
          out_hit        <= 1'b0;
          out_miss_err   <= 1'b1;
          out_idx        <= '0;
          out_next_state <= '0;
          out_cap_ena    <= 1'b0;
          out_cap_lid    <= '0;
          out_cap_ltype  <= '0;
          out_cap_flags  <= '0;
          out_done       <= 1'b1;
          out_bypass     <= '0;
          out_err_lev    <= '0;
          out_err_code   <= '0;
          out_dp0_off    <= '0;
          out_dp1_off    <= '0;
          out_dp2_off    <= '0;
          out_next_ptr   <= in_ptr;
        end
      end
    end
  end

endmodule

// File: rtl/hsp_checker.sv
module hsp_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ENT_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic                   out_hit,
  input logic                   out_miss_err,
  input logic                   out_done,
  input logic                   stage_en,
  input logic                   any_hit,
  input logic [NUM_ENTRIES-1:0] hit_vec,
  input logic [NUM_ENTRIES-1:0] win_oh,
  input logic [NUM_ENTRIES-1:0] dis,
  input logic [ENT_W-1:0]       win_idx
);

  logic [NUM_ENTRIES-1:0] below_win;
  assign below_win = (NUM_ENTRIES'(1) << win_idx) - NUM_ENTRIES'(1);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R11
  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_miss_err && out_done));  // R6
  AST_HIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> !out_miss_err);  // R6
  AST_STAGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stage_en) |=> !out_hit);  // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));  // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[win_idx] && ((hit_vec & below_win) == '0)));  // R3
  AST_DIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> !dis[win_idx]);  // R4
  AST_HIT_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_hit == $past(any_hit)));  // R11

endmodule

bind hdr_stage_tcam hsp_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ENT_W       (ENT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_hit      (out_hit),
  .out_miss_err (out_miss_err),
  .out_done     (out_done),
  .stage_en     (stage_en_w),
  .any_hit      (any_hit_w),
  .hit_vec      (hit_vec_w),
  .win_oh       (win_oh_w),
  .dis          (dis_w),
  .win_idx      (win_idx_w)
);

// File: tb/test_hdr_stage_tcam.sv
module test_hdr_stage_tcam;

  localparam int NE = 8;
  localparam int IW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_kind = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_state = '0, in_dp0 = '0, in_dp1 = '0, in_dp2 = '0, in_ptr = '0;
  logic        out_valid, out_hit, out_miss_err, out_cap_ena, out_done;
  logic [2:0]  out_idx, out_cap_lid, out_bypass;
  logic [3:0]  out_cap_ltype, out_err_lev;
  logic [7:0]  out_next_state, out_cap_flags, out_err_code;
  logic [7:0]  out_dp0_off, out_dp1_off, out_dp2_off, out_next_ptr;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the programmed contents
  logic [31:0] m_val [NE];
  logic [31:0] m_msk [NE];
  logic [63:0] m_a0  [NE];
  logic [63:0] m_a1  [NE];
  logic        m_dis [NE];
  logic        m_en;

  always #2 clk = ~clk;

  hdr_stage_tcam #(.NUM_ENTRIES(NE), .IDX_W(IW)) i_hdr_stage_tcam (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_state(in_state), .in_dp0(in_dp0), .in_dp1(in_dp1), .in_dp2(in_dp2),
    .in_ptr(in_ptr), .out_valid(out_valid), .out_hit(out_hit),
    .out_miss_err(out_miss_err), .out_idx(out_idx),
    .out_next_state(out_next_state), .out_cap_ena(out_cap_ena),
    .out_cap_lid(out_cap_lid), .out_cap_ltype(out_cap_ltype),
    .out_cap_flags(out_cap_flags), .out_done(out_done),
    .out_bypass(out_bypass), .out_err_lev(out_err_lev),
    .out_err_code(out_err_code), .out_dp0_off(out_dp0_off),
    .out_dp1_off(out_dp1_off), .out_dp2_off(out_dp2_off),
    .out_next_ptr(out_next_ptr));

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] act_pack();
    return {13'd0, out_valid, out_hit, out_miss_err, 5'd0, out_idx, out_next_state,
            out_cap_ena, out_cap_lid, out_cap_ltype, out_cap_flags, out_done,
            out_bypass, out_err_lev, out_err_code, out_dp0_off, out_dp1_off,
            out_dp2_off, out_next_ptr};
  endfunction

  function automatic logic [95:0] exp_pack(input logic [7:0] st, d0, d1, d2, p);
    logic [31:0] key;
    int win, f, v, sh, sel, np;
    logic [63:0] a0, a1;
    key = {d2, d1, d0, st};
    win = -1;
    for (int i = NE - 1; i >= 0; i--)
      if (m_en && !m_dis[i] && (((key ^ m_val[i]) & m_msk[i]) == 32'd0)) win = i;
    if (win < 0)
      return {13'd0, 1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 1'b0, 3'd0, 4'd0, 8'd0, 1'b1,
              3'd0, 4'd0, 8'd0, 8'd0, 8'd0, 8'd0, p};
    a0 = m_a0[win];
    a1 = m_a1[win];
    sel = int'(a0[37:36]);
    sh  = int'(a0[49:47]);
    f = (sel == 1) ? int'(d0) : (sel == 2) ? int'(d1) : int'(d2);
    v = f & int'(a0[45:38]);
    if (a0[46]) v = v / (1 << sh);
    else v = (v * (1 << sh)) % 256;
    np = int'(p) + int'(a0[35:28]) + ((sel != 0) ? v : 0);
    return {13'd0, 1'b1, 1'b1, 1'b0, 8'(win), a0[7:0], a0[8], a0[11:9], a0[15:12],
            a0[23:16], a0[24], a0[27:25], a1[3:0], a1[11:4], a1[19:12], a1[27:20],
            a1[35:28], 8'(np % 256)};
  endfunction

  task automatic model_write(input logic [2:0] k, input int idx, input logic [63:0] d);
    if (k == 3'd0 && idx < NE) begin m_val[idx] = d[31:0]; m_msk[idx] = d[63:32]; end
    if (k == 3'd1 && idx < NE) m_a0[idx] = d;
    if (k == 3'd2 && idx < NE) m_a1[idx] = d;
    if (k == 3'd3 && idx == 0) for (int i = 0; i < NE; i++) m_dis[i] = d[i];
    if (k == 3'd4) m_en = d[0];
  endtask

  task automatic cfg_write(input logic [2:0] k, input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(k, idx, d);
  endtask

  task automatic lookup_chk(input logic [7:0] st, d0, d1, d2, p, input string tag);
    logic [95:0] e, a;
    e = exp_pack(st, d0, d1, d2, p);
    @(negedge clk);
    in_valid = 1'b1; in_state = st; in_dp0 = d0; in_dp1 = d1; in_dp2 = d2; in_ptr = p;
    @(negedge clk);
    in_valid = 1'b0;
    a = act_pack();
    chk(a === e, tag, a, e);
  endtask

  function automatic logic [63:0] cam_word(input int i);
    case (i)
      0: return {32'h0000_0FFF, 32'h0000_0510};
      1: return {32'h0000_00F0, 32'h0000_0010};
      2: return {32'h00FF_00FF, 32'h0033_002A};
      3: return {32'h8000_0001, 32'h8000_0001};
      4: return {32'h0000_00E0, 32'h0000_00A0};
      5: return {32'h0000_0080, 32'h0000_0080};
      6: return {32'h0000_FF00, 32'h0000_FF00};
      default: return {32'h0000_00FF, 32'h0000_0000};
    endcase
  endfunction

  function automatic logic [63:0] act0_word(input int i);
    logic [2:0] b;
    b = 3'(i);
    return {14'd0, 3'(i % 3), b[1], 8'(8'hF0 >> i), 2'(i % 4), 8'(4 + i), b,
            (i == 3), 8'(i * 17), 4'(15 - i), b, b[0], 8'(8'h40 + i)};
  endfunction

  function automatic logic [63:0] act1_word(input int i);
    return {28'd0, 8'(3 * i + 1), 8'(2 * i), 8'(i), 8'(8'hA0 + i), 4'(i)};
  endfunction

  task automatic sweep(input string tag);
    for (int s = 0; s < 256; s++) begin
      for (int pat = 0; pat < 4; pat++) begin
        logic [7:0] st, d0, d1, d2;
        st = 8'(s);
        d0 = (pat == 0) ? 8'h05 : (pat == 1) ? 8'hFF : 8'(s + pat * 37);
        d1 = (pat == 2) ? 8'h33 : ~st;
        d2 = {pat[0], st[6:0]};
        lookup_chk(st, d0, d1, d2, st ^ 8'h5A, tag);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [95:0] e, a;
    for (int i = 0; i < NE; i++) begin
      m_val[i] = '0; m_msk[i] = '0; m_a0[i] = '0; m_a1[i] = '0; m_dis[i] = 1'b1;
    end
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_hit === 1'b0, "R11 reset outputs",
        96'({out_valid, out_hit}), 96'd0);

    // R5 stage off after reset: everything misses
    lookup_chk(8'h00, 8'h00, 8'h00, 8'h00, 8'h21, "R5/R6 reset miss");
    cfg_write(3'd4, 0, 64'd1);
    // R4 all entries still disabled after reset
    lookup_chk(8'h00, 8'h00, 8'h00, 8'h00, 8'h22, "R4 reset disabled");

    for (int i = 0; i < NE; i++) begin
      cfg_write(3'd0, i, cam_word(i));
      cfg_write(3'd1, i, act0_word(i));
      cfg_write(3'd2, i, act1_word(i));
    end
    cfg_write(3'd3, 0, 64'hFFFF_FFFF_FFFF_FF00);
    sweep("R1/R2/R3/R6/R7/R8/R9 full sweep");

    // R11 idle cycle after a lookup
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle", 96'(out_valid), 96'd0);

    // R4 disable entries 0 and 3, lower entries fall through
    cfg_write(3'd3, 0, 64'hFFFF_FFFF_FFFF_FF09);
    sweep("R4/R3 sweep with disabled entries");

    // R4 word selection: word 1 and an unused word number do not touch entries 0..7
    cfg_write(3'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(3'd3, 1, 64'd0);
    cfg_write(3'd3, 2, 64'd0);
    lookup_chk(8'h00, 8'h00, 8'h00, 8'h00, 8'h30, "R4 other disable words");
    cfg_write(3'd3, 0, 64'hFFFF_FFFF_FFFF_FF00);

    // R10 writes at index NE and above are ignored (no aliasing onto entry 0)
    cfg_write(3'd0, NE, 64'd0);
    cfg_write(3'd1, NE, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(3'd2, NE + 64, 64'hFFFF_FFFF_FFFF_FFFF);
    sweep("R10 sweep after out-of-range writes");

    // R12 write and lookup in the same cycle: entry 7 wins for state 0
    e = exp_pack(8'h00, 8'h01, 8'h02, 8'h03, 8'h10);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'd1; cfg_idx = IW'(7); cfg_wdata = act0_word(2);
    in_valid = 1'b1; in_state = 8'h00; in_dp0 = 8'h01; in_dp1 = 8'h02; in_dp2 = 8'h03;
    in_ptr = 8'h10;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    a = act_pack();
    chk(a === e, "R12 same-cycle lookup sees old action", a, e);
    model_write(3'd1, 7, act0_word(2));
    lookup_chk(8'h00, 8'h01, 8'h02, 8'h03, 8'h10, "R12 next lookup sees new action");

    // R5 stage disabled again
    cfg_write(3'd4, 0, 64'd0);
    lookup_chk(8'h00, 8'h01, 8'h02, 8'h03, 8'h44, "R5 stage off");
    lookup_chk(8'h10, 8'h05, 8'h00, 8'h00, 8'h45, "R5 stage off second key");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule